// File: doc/BRIEF.md
# Serial Link Break Sequencer

This block produces the two maintenance patterns of a two-wire serial link: a clock line that the block always drives, and a data line that it drives or leaves released. A one-cycle `startBreak` pulse runs the link-reset pattern. That pattern has four parts. The data wire is high for a short preamble and then low for a long stretch. It then goes high for a short echo gap and stays high for a very long recovery run. The block then waits a fixed number of system clocks so that the far end can settle. A one-cycle `startInit` pulse runs the power-up flush instead: a run of link clocks with the data wire high, which clears any stale bits out of the far end.

The link is active low, so a high wire carries a logical zero. The outputs here are wire levels. Each link clock is a low half-period followed by a high half-period. Each half-period lasts a parameterised number of system clocks. Consecutive link clocks, including those that cross from one pattern part into the next, follow one another with no gap. Between sequences the clock line rests high. When a sequence ends, the block raises `seqDone` for one cycle.

Top module: `brkseq_top`

## Requirements
- R1: While reset is held and after it is released, `linkClk` is 1, `linkDataOut` is 1, `linkDataOe` is 0 and `seqDone` is 0.
- R2: During a sequence, each low and each high half-period of `linkClk` lasts exactly HALF_DIV system clocks. Every sequence begins with a falling edge of `linkClk`.
- R3: A break sequence begins with PRE_CLKS link clocks, counted at rising edges of `linkClk`, during which `linkDataOut` is 1.
- R4: The preamble is followed by LOW_CLKS link clocks during which `linkDataOut` is 0.
- R5: The low run is followed by ECHO_CLKS + RECOV_CLKS link clocks during which `linkDataOut` is 1. After that, the data line stays at 1.
- R6: After a break, `seqDone` is sampled high exactly HALF_DIV + SETTLE_CYC system clocks after the last rising edge of `linkClk`.
- R7: An init sequence issues FLUSH_CLKS link clocks with `linkDataOut` at 1. `seqDone` is sampled high exactly HALF_DIV system clocks after the last rising edge.
- R8: `seqDone` is a single-cycle pulse, issued exactly once per sequence. At that point `linkClk` is 1, and it stays at 1 until the next request.
- R9: A `startBreak` or `startInit` pulse that arrives while a sequence, including its settle wait, is running has no effect. The number of link clocks, the data pattern and the number of done pulses do not change.
- R10: `linkDataOe` rises when the first sequence starts and stays at 1 until reset.
- R11: If `startBreak` and `startInit` arrive in the same cycle while the block is idle, the break sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startBreak | input | 1 | One-cycle request for a link-reset sequence |
| startInit | input | 1 | One-cycle request for the power-up flush sequence |
| linkClk | output | 1 | Link clock wire level; rests high |
| linkDataOut | output | 1 | Data wire level while driven (high means logical zero) |
| linkDataOe | output | 1 | Data wire drive enable; 0 leaves the wire released |
| seqDone | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench records the data level at every rising edge of the link clock and the length of every half-period, so that it can compare the whole pattern bit by bit. A design that lost a clock or added one at a boundary between pattern parts would show up as a wrong total count or as a run moved by one clock. A design that let the clock fall after the last high phase would add an extra short half-period. The bench measures the exact distance from the last rising edge to the done pulse. This catches a settle wait that is off by one, and a flush that wrongly includes the settle wait. Start requests are also injected in the middle of a break, in the middle of a flush, and together on one idle cycle. A design that restarted on such a request, or that chose the flush, would produce a longer pattern, a wrong pattern or a second done pulse.

// File: rtl/brkseq_pkg.sv
package brkseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOW,
    ST_ECHO,
    ST_RECOV,
    ST_SETTLE,
    ST_FLUSH
  } seqState_t;

  // strobes from the sequencer FSM to the line datapath
  typedef struct packed {
    logic loadPre;
    logic loadLow;
    logic loadEcho;
    logic loadRecov;
    logic loadFlush;
    logic run;
    logic settleLoad;
    logic settleRun;
  } lineStrobe_t;

endpackage

// File: rtl/brkseq_line.sv
module brkseq_line
  import brkseq_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int PRE_CLKS   = 50,
  parameter int LOW_CLKS   = 256,
  parameter int ECHO_CLKS  = 16,
  parameter int RECOV_CLKS = 16000,
  parameter int FLUSH_CLKS = 5000,
  parameter int SETTLE_CYC = 20000
) (
  input  logic        clk,
  input  logic        rstN,
  input  lineStrobe_t str,
  output logic        lastClkEnd,
  output logic        settleEnd,
  output logic        linkClk,
  output logic        linkDataOut,
  output logic        linkDataOe
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_CLKS = maxOf(maxOf(maxOf(PRE_CLKS, LOW_CLKS), maxOf(ECHO_CLKS, RECOV_CLKS)), FLUSH_CLKS);
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam int HALF_W   = $clog2(HALF_DIV + 1);
  localparam int SET_W    = $clog2(SETTLE_CYC + 1);

  logic [HALF_W-1:0] halfCnt;
  logic [CNT_W-1:0]  clkLeft;
  logic [SET_W-1:0]  settleCnt;
  logic              lcQ, dQ, oeQ;

  logic              anyLoad, loadLvl, halfEnd;
  logic [CNT_W-1:0]  loadVal;

  assign anyLoad = str.loadPre | str.loadLow | str.loadEcho | str.loadRecov | str.loadFlush;
  assign halfEnd = (halfCnt == HALF_W'(HALF_DIV - 1));

  always_comb begin
    loadVal = CNT_W'(FLUSH_CLKS);
    loadLvl = 1'b1;
    if (str.loadPre)        loadVal = CNT_W'(PRE_CLKS);
    else if (str.loadLow) begin
      loadVal = CNT_W'(LOW_CLKS);
      loadLvl = 1'b0;
    end
    else if (str.loadEcho)  loadVal = CNT_W'(ECHO_CLKS);
    else if (str.loadRecov) loadVal = CNT_W'(RECOV_CLKS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      clkLeft <= '0;
      lcQ     <= 1'b1;
      dQ      <= 1'b1;
      oeQ     <= 1'b0;
    end else if (anyLoad) begin
      clkLeft <= loadVal;
      halfCnt <= '0;
      lcQ     <= 1'b0;
      dQ      <= loadLvl;
      oeQ     <= 1'b1;
    end else if (str.run) begin
      if (halfEnd) begin
        halfCnt <= '0;
        if (!lcQ) begin
          lcQ <= 1'b1;
        end else begin
          clkLeft <= clkLeft - 1'b1;
          if (clkLeft != CNT_W'(1)) lcQ <= 1'b0;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  settleCnt <= '0;
    else if (str.settleLoad)                    settleCnt <= SET_W'(SETTLE_CYC);
    else if (str.settleRun && settleCnt != '0)  settleCnt <= settleCnt - 1'b1;
  end

  assign lastClkEnd  = str.run && lcQ && halfEnd && (clkLeft == CNT_W'(1));
  assign settleEnd   = str.settleRun && (settleCnt == SET_W'(1));
  assign linkClk     = lcQ;
  assign linkDataOut = dQ;
  assign linkDataOe  = oeQ;

endmodule

// File: rtl/brkseq_ctrl.sv
module brkseq_ctrl
  import brkseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startBreak,
  input  logic        startInit,
  input  logic        lastClkEnd,
  input  logic        settleEnd,
  output lineStrobe_t str,
  output logic        seqDone
);

  seqState_t state, nxtState;
  logic      doneNxt, doneQ;

  always_comb begin
    str      = '0;
    nxtState = state;
    doneNxt  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startBreak) begin
          str.loadPre = 1'b1;
          nxtState    = ST_PRE;
        end else if (startInit) begin
          str.loadFlush = 1'b1;
          nxtState      = ST_FLUSH;
        end
      end
      ST_PRE: begin
        str.run = 1'b1;
        if (lastClkEnd) begin
          str.loadLow = 1'b1;
          nxtState    = ST_LOW;
        end
      end
      ST_LOW: begin
        str.run = 1'b1;
        if (lastClkEnd) begin
          str.loadEcho = 1'b1;
          nxtState     = ST_ECHO;
        end
      end
      ST_ECHO: begin
        str.run = 1'b1;
        if (lastClkEnd) begin
          str.loadRecov = 1'b1;
          nxtState      = ST_RECOV;
        end
      end
      ST_RECOV: begin
        str.run = 1'b1;
        if (lastClkEnd) begin
          str.settleLoad = 1'b1;
          nxtState       = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        str.settleRun = 1'b1;
        if (settleEnd) begin
          doneNxt  = 1'b1;
          nxtState = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        str.run = 1'b1;
        if (lastClkEnd) begin
          doneNxt  = 1'b1;
          nxtState = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= nxtState;
      doneQ <= doneNxt;
    end
  end

  assign seqDone = doneQ;

endmodule

// File: rtl/brkseq_top.sv
module brkseq_top
  import brkseq_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int PRE_CLKS   = 50,
  parameter int LOW_CLKS   = 256,
  parameter int ECHO_CLKS  = 16,
  parameter int RECOV_CLKS = 16000,
  parameter int FLUSH_CLKS = 5000,
  parameter int SETTLE_CYC = 20000
) (
  input  logic clk,
  input  logic rstN,
  input  logic startBreak,
  input  logic startInit,
  output logic linkClk,
  output logic linkDataOut,
  output logic linkDataOe,
  output logic seqDone
);

  lineStrobe_t str;
  logic        lastClkEnd, settleEnd;

  brkseq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startBreak (startBreak),
    .startInit  (startInit),
    .lastClkEnd (lastClkEnd),
    .settleEnd  (settleEnd),
    .str        (str),
    .seqDone    (seqDone)
  );

  brkseq_line #(
    .HALF_DIV   (HALF_DIV),
    .PRE_CLKS   (PRE_CLKS),
    .LOW_CLKS   (LOW_CLKS),
    .ECHO_CLKS  (ECHO_CLKS),
    .RECOV_CLKS (RECOV_CLKS),
    .FLUSH_CLKS (FLUSH_CLKS),
    .SETTLE_CYC (SETTLE_CYC)
  ) line_i (
    .clk         (clk),
    .rstN        (rstN),
    .str         (str),
    .lastClkEnd  (lastClkEnd),
    .settleEnd   (settleEnd),
    .linkClk     (linkClk),
    .linkDataOut (linkDataOut),
    .linkDataOe  (linkDataOe)
  );

endmodule

// File: rtl/brkseq_chk.sv
module brkseq_chk (
  input logic clk,
  input logic rstN,
  input logic linkClk,
  input logic linkDataOut,
  input logic linkDataOe,
  input logic seqDone
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // R8
  done_clk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (linkClk && $past(linkClk)));

  // R10
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkDataOe |=> linkDataOe);

  // R1
  released_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkDataOe |-> (linkClk && linkDataOut && !seqDone));

  // R5
  data_high_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> linkDataOut);

endmodule

bind brkseq_top brkseq_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .linkClk     (linkClk),
  .linkDataOut (linkDataOut),
  .linkDataOe  (linkDataOe),
  .seqDone     (seqDone)
);

// File: tb/brkseq_top_tb_top.sv
module brkseq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF   = 2;
  localparam int PRE    = 3;
  localparam int LOWC   = 5;
  localparam int ECHO   = 2;
  localparam int RECOV  = 7;
  localparam int FLUSH  = 4;
  localparam int SETTLE = 6;

  typedef struct packed {
    logic doBreak;
    logic doInit;
    int   interfereAt;
  } vec_t;

  // stimulus rows: break, init, both together, break hit mid-run, init hit mid-run
  localparam vec_t VECS [5] = '{
    '{1'b1, 1'b0, 0},
    '{1'b0, 1'b1, 0},
    '{1'b1, 1'b1, 0},
    '{1'b1, 1'b0, 20},
    '{1'b0, 1'b1, 6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startBreak = 1'b0;
  logic startInit = 1'b0;
  logic linkClk, linkDataOut, linkDataOe, seqDone;

  brkseq_top #(
    .HALF_DIV(HALF), .PRE_CLKS(PRE), .LOW_CLKS(LOWC), .ECHO_CLKS(ECHO),
    .RECOV_CLKS(RECOV), .FLUSH_CLKS(FLUSH), .SETTLE_CYC(SETTLE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startBreak(startBreak), .startInit(startInit),
    .linkClk(linkClk), .linkDataOut(linkDataOut), .linkDataOe(linkDataOe), .seqDone(seqDone)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // line monitor, sampled at the falling system clock edge
  int   cyc = 0;
  logic prevLc = 1'b1;
  logic prevDone = 1'b0;
  bit   inSeq = 1'b0;
  int   runLen = 0;
  int   nRise = 0;
  int   nDone = 0;
  int   lastRise = 0;
  int   doneCyc = 0;
  int   halfBad = 0;
  int   widthBad = 0;
  int   oeBad = 0;
  logic patt [0:511];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN) begin
      if (linkClk !== prevLc) begin
        if (linkClk) begin
          if (runLen != HALF) halfBad = halfBad + 1;
          if (nRise < 512) patt[nRise] = linkDataOut;
          nRise = nRise + 1;
          lastRise = cyc;
        end else begin
          if (inSeq && runLen != HALF) halfBad = halfBad + 1;
          inSeq = 1'b1;
        end
        runLen = 1;
      end else begin
        runLen = runLen + 1;
      end
      if (inSeq && !linkDataOe) oeBad = oeBad + 1;
      if (seqDone) begin
        nDone = nDone + 1;
        doneCyc = cyc;
        inSeq = 1'b0;
        if (prevDone) widthBad = widthBad + 1;
      end
    end
    prevLc = linkClk;
    prevDone = seqDone;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic expLvl(input bit isBreak, input int i);
    if (!isBreak) return 1'b1;
    if (i < PRE) return 1'b1;
    if (i < PRE + LOWC) return 1'b0;
    return 1'b1;
  endfunction

  task automatic runVec(input vec_t v);
    int baseRise, baseDone, baseHalf, baseW, baseOe, t, expRise, expDelay, bad;
    bit isBreak;
    isBreak  = v.doBreak;
    expRise  = isBreak ? (PRE + LOWC + ECHO + RECOV) : FLUSH;
    expDelay = isBreak ? (HALF + SETTLE) : HALF;
    baseRise = nRise; baseDone = nDone; baseHalf = halfBad; baseW = widthBad; baseOe = oeBad;
    @(negedge clk);
    startBreak = v.doBreak;
    startInit  = v.doInit;
    @(negedge clk);
    startBreak = 1'b0;
    startInit  = 1'b0;
    if (v.interfereAt > 0) begin
      repeat (v.interfereAt) @(negedge clk);
      startBreak = 1'b1;
      startInit  = 1'b1;
      @(negedge clk);
      startBreak = 1'b0;
      startInit  = 1'b0;
    end
    t = 0;
    while (nDone == baseDone && t < 5000) begin
      @(negedge clk);
      t = t + 1;
    end
    chk(t < 5000, "R8 done seen", t, 0);
    repeat (40) @(negedge clk);
    // R3 R4 R5 R7 R9 R11: rise count and pattern
    chk(nRise - baseRise == expRise, isBreak ? "R3 R4 R5 R9 R11 link clock count" : "R7 R9 flush clock count",
        nRise - baseRise, expRise);
    bad = 0;
    for (int i = 0; i < expRise && i < nRise - baseRise; i++)
      if (patt[baseRise + i] !== expLvl(isBreak, i)) bad = bad + 1;
    chk(bad == 0, isBreak ? "R3 R4 R5 break data pattern" : "R7 flush data pattern", bad, 0);
    chk(halfBad == baseHalf, "R2 half-period length", halfBad - baseHalf, 0);
    chk(nDone - baseDone == 1, "R8 R9 done pulse count", nDone - baseDone, 1);
    chk(widthBad == baseW, "R8 done width", widthBad - baseW, 0);
    chk(doneCyc - lastRise == expDelay, isBreak ? "R6 settle delay" : "R7 flush done delay",
        doneCyc - lastRise, expDelay);
    chk(oeBad == baseOe, "R10 drive enable during sequence", oeBad - baseOe, 0);
    chk(linkClk === 1'b1 && linkDataOut === 1'b1, "R8 R5 idle line high", {linkClk, linkDataOut}, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors = errors + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(linkClk === 1'b1, "R1 clock in reset", linkClk, 1);
    chk(linkDataOe === 1'b0, "R1 oe in reset", linkDataOe, 0);
    chk(seqDone === 1'b0 && linkDataOut === 1'b1, "R1 done/data in reset", {seqDone, linkDataOut}, 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(linkClk === 1'b1 && linkDataOe === 1'b0 && seqDone === 1'b0, "R1 idle after reset",
        {linkClk, linkDataOe, seqDone}, 4);

    for (int k = 0; k < 5; k++) runVec(VECS[k]);

    // R10 enable stays on after sequences
    chk(linkDataOe === 1'b1, "R10 oe held", linkDataOe, 1);
    // R1 reset again returns the line to released
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(linkDataOe === 1'b0 && linkClk === 1'b1, "R1 re-reset", {linkDataOe, linkClk}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule